// File: doc/BRIEF.md
# Receive Power-Up and Offset Calibration Sequencer

This block brings a two-channel (I and Q) receive path out of sleep. When the path is enabled, it steps through four timed phases: a fixed settling interval, a programmable first wait, an optional offset-calibration window and a programmable second wait. It then raises `ready`, which tells downstream logic that output words are valid. All phase lengths are counted in units of 48 master clocks.

During the calibration window the block averages the first 16 converter samples of each channel and loads the result into that channel's 10-bit offset register. The external datapath subtracts this value from the filtered data. In internal mode, a control output shorts the converter inputs for the whole window. In external mode the inputs stay on the pins, so offsets from the board are measured as well. When calibration is switched off, the window is skipped and the host loads the offset registers directly. The offset registers hold their contents while the path sleeps.

The modulator and the decimation filter are outside this block. They appear here only as a sample strobe with two signed sample words.

Top module: `rx_cal_sequencer`

## Requirements
- R1: The receive path is active when `en_pin` or `en_bit` is high. Either one alone starts the sequence.
- R2: One time unit is 48 clock cycles. The settle phase is 36 units long and always comes first.
- R3: The first and second waits last `delay1` and `delay2` units (0 to 255). A value of zero removes that phase completely.
- R4: With `autocal_en` = 1 the calibration phase lasts 40 units and starts (36 + `delay1`) × 48 edges after the first edge that samples the path active. With `autocal_en` = 0 it takes no time.
- R5: `inputs_short` is high exactly during the calibration phase when `ext_cal` = 0. With `ext_cal` = 1 it stays low.
- R6: In the calibration phase, each edge with `smp_valid` high accumulates the two's-complement samples until 16 samples per channel are taken. On the edge of the 16th sample, each offset becomes (sum >>> 4) >>> 3, clamped to the range −512..511 and stored as a 10-bit two's-complement value. The registers are not updated if the path is inactive on that edge.
- R7: While `autocal_en` = 0, a high `ofs_wr` loads `ofs_wdata` into the Q register when `ofs_sel` = 1 and into the I register when `ofs_sel` = 0. While `autocal_en` = 1, host writes are ignored.
- R8: The offset registers keep their values when the path is disabled and re-enabled.
- R9: `ready` rises (36 + `delay1` + C + `delay2`) × 48 edges after the first edge that samples the path active, where C is 40 or 0 as in R4. It stays high while the path stays active.
- R10: When the path becomes inactive, `ready` and `inputs_short` fall in the same cycle, with no clock edge needed. The next activation restarts the sequence from the settle phase.
- R11: During reset and after it, `ready` and `inputs_short` are low and both offset registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable from the external pin |
| en_bit | input | 1 | Enable from the control register |
| autocal_en | input | 1 | 1 = run automatic offset calibration |
| ext_cal | input | 1 | 1 = keep inputs connected during calibration |
| delay1 | input | 8 | First wait, in 48-clock units |
| delay2 | input | 8 | Second wait, in 48-clock units |
| ofs_wr | input | 1 | Host offset write strobe |
| ofs_sel | input | 1 | Host write target: 0 = I, 1 = Q |
| ofs_wdata | input | 10 | Host offset value |
| smp_valid | input | 1 | Converter sample strobe |
| smp_i | input | 16 | I-channel sample, two's complement |
| smp_q | input | 16 | Q-channel sample, two's complement |
| inputs_short | output | 1 | Short the converter inputs |
| ready | output | 1 | Sequence complete, output words valid |
| ofs_i | output | 10 | I-channel offset register |
| ofs_q | output | 10 | Q-channel offset register |

## Verification
The critical collision is between the enable being withdrawn and the 16th calibration sample, because both want to act on the same clock edge. The bench uses its reference model to find the cycle just before the final sample would be accepted. In that cycle it presents a valid sample and drops the enable together. It then expects both offset registers to keep their earlier values and `ready` to stay low until a fresh activation runs the complete sequence again. A second collision, a host write issued while autocalibration owns the registers, is judged by reading the offset outputs on the following cycles.

// File: rtl/rx_cal_sequencer.sv
module rx_cal_sequencer #(
  parameter int UNIT_CLKS    = 48,
  parameter int SETTLE_UNITS = 36,
  parameter int CAL_UNITS    = 40,
  parameter int DLY_W        = 8,
  parameter int AVG_LOG2     = 4,
  parameter int SMP_W        = 16,
  parameter int OFS_W        = 10,
  parameter int OFS_LSB      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pin,
  input  logic             en_bit,
  input  logic             autocal_en,
  input  logic             ext_cal,
  input  logic [DLY_W-1:0] delay1,
  input  logic [DLY_W-1:0] delay2,
  input  logic             ofs_wr,
  input  logic             ofs_sel,
  input  logic [OFS_W-1:0] ofs_wdata,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] smp_q,
  output logic             inputs_short,
  output logic             ready,
  output logic [OFS_W-1:0] ofs_i,
  output logic [OFS_W-1:0] ofs_q
);

  localparam int NAVG    = 1 << AVG_LOG2;
  localparam int ACC_W   = SMP_W + AVG_LOG2;
  localparam int SHIFT   = AVG_LOG2 + OFS_LSB;
  localparam int TICK_W  = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
  localparam int DLY_MAX = (1 << DLY_W) - 1;
  localparam int MAXU_A  = (SETTLE_UNITS > CAL_UNITS) ? SETTLE_UNITS : CAL_UNITS;
  localparam int MAXU    = (MAXU_A > DLY_MAX) ? MAXU_A : DLY_MAX;
  localparam int UW      = $clog2(MAXU + 1);
  localparam int NW      = AVG_LOG2 + 1;

  localparam logic [2:0] P_IDLE   = 3'd0;
  localparam logic [2:0] P_SETTLE = 3'd1;
  localparam logic [2:0] P_DLY1   = 3'd2;
  localparam logic [2:0] P_CAL    = 3'd3;
  localparam logic [2:0] P_DLY2   = 3'd4;
  localparam logic [2:0] P_RDY    = 3'd5;

  localparam logic signed [ACC_W-1:0] OFS_HI = ACC_W'((1 << (OFS_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OFS_LO = ~OFS_HI;

  logic              active;
  logic [2:0]        phase, nxt;
  logic [TICK_W-1:0] tick;
  logic [UW-1:0]     units, cur_len;
  logic [UW-1:0]     plen [1:4];
  logic              tick_last, phase_end;

  assign active = en_pin | en_bit;

  always_comb begin
    plen[1] = UW'(SETTLE_UNITS);
    plen[2] = UW'(delay1);
    plen[3] = autocal_en ? UW'(CAL_UNITS) : '0;
    plen[4] = UW'(delay2);
    nxt = P_RDY;
    for (int j = 4; j >= 1; j--)
      if (j > int'(phase) && plen[j] != '0) nxt = 3'(j);
    case (phase)
      P_SETTLE: cur_len = plen[1];
      P_DLY1:   cur_len = plen[2];
      P_CAL:    cur_len = plen[3];
      P_DLY2:   cur_len = plen[4];
      default:  cur_len = '0;
    endcase
  end

  assign tick_last = (tick == TICK_W'(UNIT_CLKS - 1));
  assign phase_end = tick_last && (units == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      tick  <= '0;
      units <= '0;
    end else if (!active) begin
      phase <= P_IDLE;
      tick  <= '0;
      units <= '0;
    end else if (phase == P_IDLE) begin
      phase <= nxt;
      tick  <= '0;
      units <= '0;
    end else if (phase != P_RDY) begin
      if (phase_end) begin
        phase <= nxt;
        tick  <= '0;
        units <= '0;
      end else if (tick_last) begin
        tick  <= '0;
        units <= units + 1'b1;
      end else begin
        tick  <= tick + 1'b1;
      end
    end
  end

  logic                    in_cal, take, last;
  logic [NW-1:0]           nsmp;
  logic signed [ACC_W-1:0] acc_i, acc_q, sum_i, sum_q;

  assign in_cal = active && (phase == P_CAL);
  assign take   = in_cal && smp_valid && (nsmp != NW'(NAVG));
  assign last   = take && (nsmp == NW'(NAVG - 1));
  assign sum_i  = acc_i + ACC_W'($signed(smp_i));
  assign sum_q  = acc_q + ACC_W'($signed(smp_q));

  function automatic logic [OFS_W-1:0] sat_ofs(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] sh;
    sh = s >>> SHIFT;
    if (sh > OFS_HI)      sat_ofs = OFS_HI[OFS_W-1:0];
    else if (sh < OFS_LO) sat_ofs = OFS_LO[OFS_W-1:0];
    else                  sat_ofs = sh[OFS_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsmp  <= '0;
      acc_i <= '0;
      acc_q <= '0;
    end else if (!in_cal) begin
      nsmp  <= '0;
      acc_i <= '0;
      acc_q <= '0;
    end else if (take) begin
      nsmp  <= nsmp + 1'b1;
      acc_i <= sum_i;
      acc_q <= sum_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_i <= '0;
      ofs_q <= '0;
    end else if (last) begin
      ofs_i <= sat_ofs(sum_i);
      ofs_q <= sat_ofs(sum_q);
    end else if (ofs_wr && !autocal_en) begin
      if (ofs_sel) ofs_q <= ofs_wdata;
      else         ofs_i <= ofs_wdata;
    end
  end

  assign inputs_short = in_cal && !ext_cal;
  assign ready        = active && (phase == P_RDY);

endmodule

// File: rtl/rx_cal_sequencer_chk.sv
module rx_cal_sequencer_chk #(
  parameter int OFS_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_pin,
  input logic             en_bit,
  input logic             autocal_en,
  input logic             ext_cal,
  input logic             ofs_wr,
  input logic             smp_valid,
  input logic             inputs_short,
  input logic             ready,
  input logic [OFS_W-1:0] ofs_i,
  input logic [OFS_W-1:0] ofs_q
);

  // R10
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_pin || en_bit) |=> !ready);

  // R5
  short_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inputs_short |-> (autocal_en && !ext_cal && !ready));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (ready || !(en_pin || en_bit)));

  // R6
  ofs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(ofs_i) && $stable(ofs_q)) |-> ($past(ofs_wr && !autocal_en) || $past(smp_valid)));

  // R7
  host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autocal_en && ofs_wr && !smp_valid) |=> ($stable(ofs_i) && $stable(ofs_q)));

endmodule

bind rx_cal_sequencer rx_cal_sequencer_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_bit(en_bit),
  .autocal_en(autocal_en), .ext_cal(ext_cal), .ofs_wr(ofs_wr),
  .smp_valid(smp_valid), .inputs_short(inputs_short), .ready(ready),
  .ofs_i(ofs_i), .ofs_q(ofs_q)
);

// File: tb/rx_cal_sequencer_tb.sv
module rx_cal_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT   = 48;
  localparam int SETTLE = 36;
  localparam int CALU   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, en_bit = 1'b0, autocal_en = 1'b0, ext_cal = 1'b0;
  logic [7:0] delay1 = '0, delay2 = '0;
  logic ofs_wr = 1'b0, ofs_sel = 1'b0;
  logic [9:0] ofs_wdata = '0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_i = '0, smp_q = '0;
  logic inputs_short, ready;
  logic [9:0] ofs_i, ofs_q;

  rx_cal_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_bit(en_bit),
    .autocal_en(autocal_en), .ext_cal(ext_cal), .delay1(delay1), .delay2(delay2),
    .ofs_wr(ofs_wr), .ofs_sel(ofs_sel), .ofs_wdata(ofs_wdata),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .inputs_short(inputs_short), .ready(ready), .ofs_i(ofs_i), .ofs_q(ofs_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit running = 0, big = 0, kill_arm = 0, kill_done = 0;
  int elapsed = 0, mn = 0, msum_i = 0, msum_q = 0;
  logic [9:0] exp_i = '0, exp_q = '0;

  task automatic chk(input string tag, input int got, input int expv);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  function automatic int win_lo();
    return (SETTLE + int'(delay1)) * UNIT;
  endfunction
  function automatic int win_hi();
    return win_lo() + CALU * UNIT;
  endfunction
  function automatic int n_total();
    return (SETTLE + int'(delay1) + (autocal_en ? CALU : 0) + int'(delay2)) * UNIT;
  endfunction
  function automatic logic [9:0] sat10(input int s);
    int t;
    t = s >>> 7;
    if (t > 511) t = 511;
    if (t < -512) t = -512;
    return 10'(t);
  endfunction
  function automatic bit in_win();
    return running && autocal_en && elapsed >= win_lo() && elapsed < win_hi();
  endfunction

  // reference model, updated on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      running = 0; elapsed = 0; mn = 0; msum_i = 0; msum_q = 0;
      exp_i = '0; exp_q = '0;
    end else begin
      if ((en_pin | en_bit) && in_win()) begin
        if (smp_valid && mn < 16) begin
          msum_i = msum_i + int'($signed(smp_i));
          msum_q = msum_q + int'($signed(smp_q));
          mn++;
          if (mn == 16) begin
            exp_i = sat10(msum_i);
            exp_q = sat10(msum_q);
          end
        end
      end else begin
        mn = 0; msum_i = 0; msum_q = 0;
      end
      if (ofs_wr && !autocal_en) begin
        if (ofs_sel) exp_q = ofs_wdata;
        else         exp_i = ofs_wdata;
      end
      if (en_pin | en_bit) begin
        if (!running) begin running = 1; elapsed = 0; end
        else if (elapsed < 1000000) elapsed++;
      end else running = 0;
    end
  end

  // sample source and last-sample collision
  always @(posedge clk) begin
    #1;
    cyc++;
    smp_valid = (cyc % 3 == 0);
    if (big) begin
      smp_i = 16'sd30000;
      smp_q = -16'sd30000;
    end else begin
      smp_i = 16'((cyc * 37) % 2000 - 1000);
      smp_q = 16'((cyc * 53) % 3000 - 1500);
    end
    if (kill_arm && (en_pin | en_bit) && mn == 15 && in_win()) begin
      smp_valid = 1'b1;
      en_pin = 1'b0;
      en_bit = 1'b0;
      kill_arm = 0;
      kill_done = 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ready", int'(ready),
          int'(running && (en_pin | en_bit) && elapsed >= n_total()));
      chk("R5 inputs_short", int'(inputs_short),
          int'((en_pin | en_bit) && in_win() && !ext_cal));
      chk("R6 ofs_i", int'(ofs_i), int'(exp_i));
      chk("R6 ofs_q", int'(ofs_q), int'(exp_q));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_to_ready(input string tag, input int exp_k, input int exp_sh);
    int k = 0;
    int sh_at = -1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (inputs_short && sh_at < 0) sh_at = k;
      if (ready || k > 20000) break;
      @(posedge clk);
      k++;
    end
    chk({tag, " ready latency"}, k, exp_k);
    chk({tag, " short start"}, sh_at, exp_sh);
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [9:0] keep_i, keep_q;
    step(3);
    chk("R11 ready in reset", int'(ready), 0);
    chk("R11 short in reset", int'(inputs_short), 0);
    chk("R11 ofs_i in reset", int'(ofs_i), 0);
    rst_n = 1'b1;
    step(2);
    chk("R11 ofs_q after reset", int'(ofs_q), 0);
    chk("R11 ready after reset", int'(ready), 0);

    // pin enable, internal autocal, both waits nonzero
    autocal_en = 1; ext_cal = 0; delay1 = 8'd2; delay2 = 8'd3;
    en_pin = 1;
    run_to_ready("R1/R2/R3/R4", (SETTLE + 2 + CALU + 3) * UNIT, (SETTLE + 2) * UNIT);
    chk("R6 ofs_i after autocal", int'(ofs_i), int'(exp_i));
    step(20);
    chk("R9 ready held", int'(ready), 1);
    keep_i = ofs_i; keep_q = ofs_q;
    en_pin = 0;
    #1;
    chk("R10 ready drops with enable", int'(ready), 0);
    step(50);
    chk("R8 ofs_i kept in sleep", int'(ofs_i), int'(keep_i));
    chk("R8 ofs_q kept in sleep", int'(ofs_q), int'(keep_q));

    // host writes, register enable, no calibration, zero waits
    autocal_en = 0; delay1 = 8'd0; delay2 = 8'd0;
    ofs_wr = 1; ofs_sel = 0; ofs_wdata = 10'h155;
    step(1);
    ofs_sel = 1; ofs_wdata = 10'h2AA;
    step(1);
    ofs_wr = 0;
    step(1);
    chk("R7 host write I", int'(ofs_i), 'h155);
    chk("R7 host write Q", int'(ofs_q), 'h2AA);
    en_bit = 1;
    run_to_ready("R1/R3/R4 no cal", SETTLE * UNIT, -1);
    chk("R8 host value survives run", int'(ofs_i), 'h155);
    en_bit = 0;
    step(5);

    // external calibration with saturating samples
    autocal_en = 1; ext_cal = 1; delay1 = 8'd1; delay2 = 8'd0; big = 1;
    en_pin = 1;
    run_to_ready("R4/R5 external", (SETTLE + 1 + CALU) * UNIT, -1);
    chk("R6 saturate high", int'(ofs_i), 511);
    chk("R6 saturate low", int'(ofs_q), 'h200);
    ofs_wr = 1; ofs_sel = 0; ofs_wdata = 10'h000;
    step(1);
    ofs_wr = 0;
    step(2);
    chk("R7 host write ignored", int'(ofs_i), 511);
    en_pin = 0;
    step(5);

    // enable withdrawn on the final calibration sample
    big = 0; ext_cal = 0; delay1 = 8'd0; delay2 = 8'd2;
    kill_arm = 1;
    en_pin = 1;
    for (int w = 0; w < 10000 && !kill_done; w++) step(1);
    step(2);
    chk("R6 no update on inactive last sample I", int'(ofs_i), 511);
    chk("R6 no update on inactive last sample Q", int'(ofs_q), 'h200);
    chk("R10 ready low after withdraw", int'(ready), 0);
    en_pin = 1;
    run_to_ready("R10 restart", (SETTLE + CALU + 2) * UNIT, SETTLE * UNIT);
    chk("R6 ofs_q recalibrated", int'(ofs_q), int'(exp_q));
    en_pin = 0;
    step(3);
    finish_run();
  end
endmodule